// File: doc/BRIEF.md
# Call and Interrupt Stack Sequencer

This block sits between a processor's control unit and a byte-wide stack engine. The control unit hands it one command, which is an opcode plus the current operand values. The block turns that command into an ordered run of single-byte push or pop requests. At the end it returns a restored program counter, status byte or accumulator, and it marks completion with a one-cycle done pulse.

Eight commands are supported:
- **Subroutine call:** pushes a two-byte return address, taken from a dedicated input.
- **Subroutine return:** pops two bytes and reloads the program counter.
- **Interrupt entry:** pushes the program counter and then the status byte, and loads the program counter from a supplied vector.
- **Interrupt return:** pops the status byte first, then the two address bytes.
- **Single-byte moves:** four commands push or pull the accumulator or the status byte.

Program-counter bytes are pushed high byte first, so they come back low byte first. A pop request is issued only after the previous pop's data has arrived. While `busy` is high, further commands are ignored.

Top module: `stack_frame_seq`

## Requirements
- R1: Opcode 0 (call) pushes `ret_addr` high byte, then low byte, in the two cycles after acceptance; done follows in the next cycle, with no load strobe.
- R2: Opcode 1 (return) pops two bytes; the first popped is the low byte and the second the high byte; at done `pc_load` is high and `pc_out` = {second, first}.
- R3: Opcode 2 (interrupt entry) pushes `pc_in` high byte, `pc_in` low byte, then `sr_in`, on consecutive cycles; at done `pc_load` is high and `pc_out` equals the `vec_in` captured at acceptance.
- R4: Opcode 3 (interrupt return) pops three bytes: status, then low, then high; at done `sr_load` and `pc_load` are both high, with `sr_out` = the first byte and `pc_out` = {third, second}.
- R5: Opcode 4 pushes `acc_in` and opcode 6 pushes `sr_in`, each as one byte in the cycle after acceptance, followed by done.
- R6: Opcode 5 pops one byte into `acc_out` with `acc_load`; opcode 7 pops one byte into `sr_out` with `sr_load`.
- R7: At most one of `push_en` and `pop_en` is high in any cycle. `pop_en` lasts one cycle, and the next pop is not requested until `pop_ack` has returned data.
- R8: `done` is a one-cycle pulse at the end of every command. `pc_load`, `sr_load` and `acc_load` are high only together with `done`.
- R9: `busy` is high from the cycle after acceptance through the done cycle and low afterwards. A `cmd_valid` while busy is ignored: it causes no extra stack traffic and no change to results.
- R10: After reset, `busy`, `done`, `push_en`, `pop_en` and all load strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_op | input | 3 | Command opcode (0..7) |
| pc_in | input | 2*DW | Address of the next instruction |
| ret_addr | input | 2*DW | Return address for a call |
| vec_in | input | 2*DW | Interrupt vector |
| sr_in | input | DW | Current status byte |
| acc_in | input | DW | Current accumulator |
| busy | output | 1 | Sequence in progress |
| push_en | output | 1 | Push request to the stack port |
| push_byte | output | DW | Byte to push |
| pop_en | output | 1 | Pop request to the stack port |
| pop_ack | input | 1 | Pop data valid |
| pop_byte | input | DW | Popped byte |
| pc_out | output | 2*DW | New program counter |
| pc_load | output | 1 | Load strobe for `pc_out` |
| sr_out | output | DW | Restored status byte |
| sr_load | output | 1 | Load strobe for `sr_out` |
| acc_out | output | DW | Restored accumulator |
| acc_load | output | 1 | Load strobe for `acc_out` |
| done | output | 1 | End-of-sequence pulse |

## Verification
The bench builds the block with its default byte width of 8, which gives 16-bit addresses. Against it sits a 256-byte stack model whose pointer wraps, so random runs push and pop frames across the wrap point of the stack pointer. The model answers each pop after a random delay of one to three cycles. This exercises the wait between pops and the reversed byte order of returns. Random stray commands during busy periods cover the ignore rule.

// File: rtl/stack_frame_seq.sv
module stack_frame_seq #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [2*DW-1:0] pc_in,
  input  logic [2*DW-1:0] ret_addr,
  input  logic [2*DW-1:0] vec_in,
  input  logic [DW-1:0]   sr_in,
  input  logic [DW-1:0]   acc_in,
  output logic            busy,
  output logic            push_en,
  output logic [DW-1:0]   push_byte,
  output logic            pop_en,
  input  logic            pop_ack,
  input  logic [DW-1:0]   pop_byte,
  output logic [2*DW-1:0] pc_out,
  output logic            pc_load,
  output logic [DW-1:0]   sr_out,
  output logic            sr_load,
  output logic [DW-1:0]   acc_out,
  output logic            acc_load,
  output logic            done
);
  localparam int AW = 2 * DW;
  localparam int SLOTS = 3;
  localparam logic [2:0] OP_CALL = 3'd0, OP_RET = 3'd1, OP_IRQ = 3'd2, OP_RTI = 3'd3,
                         OP_PHA = 3'd4, OP_PLA = 3'd5, OP_PHS = 3'd6, OP_PLS = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_POPREQ, S_POPWAIT, S_FIN} state_t;

  state_t        state;
  logic [2:0]    op_q;
  logic [1:0]    idx, last;
  logic [DW-1:0] slot [SLOTS];
  logic [DW-1:0] ld   [SLOTS];
  logic [AW-1:0] vec_q;
  logic [1:0]    len_m1;

  assign len_m1 = cmd_op[2] ? 2'd0 : (cmd_op[1] ? 2'd2 : 2'd1);

  always_comb begin
    ld[0] = '0;
    ld[1] = '0;
    ld[2] = '0;
    case (cmd_op)
      OP_CALL: begin ld[0] = ret_addr[AW-1:DW]; ld[1] = ret_addr[DW-1:0]; end
      OP_IRQ:  begin ld[0] = pc_in[AW-1:DW]; ld[1] = pc_in[DW-1:0]; ld[2] = sr_in; end
      OP_PHA:  ld[0] = acc_in;
      OP_PHS:  ld[0] = sr_in;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q  <= '0;
      idx   <= '0;
      last  <= '0;
      vec_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q  <= cmd_op;
          idx   <= '0;
          last  <= len_m1;
          vec_q <= vec_in;
          for (int i = 0; i < SLOTS; i++) slot[i] <= ld[i];
          state <= cmd_op[0] ? S_POPREQ : S_PUSH;
        end
        S_PUSH: begin
          idx <= idx + 2'd1;
          if (idx == last) state <= S_FIN;
        end
        S_POPREQ: state <= S_POPWAIT;
        S_POPWAIT: if (pop_ack) begin
          slot[idx] <= pop_byte;
          idx       <= idx + 2'd1;
          state     <= (idx == last) ? S_FIN : S_POPREQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = state != S_IDLE;
  assign push_en   = state == S_PUSH;
  assign push_byte = slot[idx];
  assign pop_en    = state == S_POPREQ;
  assign done      = state == S_FIN;

  assign pc_load  = done && (op_q == OP_RET || op_q == OP_IRQ || op_q == OP_RTI);
  assign sr_load  = done && (op_q == OP_RTI || op_q == OP_PLS);
  assign acc_load = done && (op_q == OP_PLA);

  assign pc_out  = (op_q == OP_IRQ) ? vec_q :
                   (op_q == OP_RTI) ? {slot[2], slot[1]} : {slot[1], slot[0]};
  assign sr_out  = slot[0];
  assign acc_out = slot[0];
endmodule

// File: rtl/stack_frame_seq_chk.sv
module stack_frame_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic push_en,
  input logic pop_en,
  input logic pc_load,
  input logic sr_load,
  input logic acc_load,
  input logic done
);
  a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en && pop_en));
  a_r7_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> !pop_en);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_load_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load || sr_load || acc_load) |-> done);
  a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r9_free_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(push_en || pop_en || done));
endmodule

bind stack_frame_seq stack_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .push_en(push_en), .pop_en(pop_en),
  .pc_load(pc_load), .sr_load(sr_load), .acc_load(acc_load), .done(done)
);

// File: tb/stack_frame_seq_tb.sv
module stack_frame_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [15:0] pc_in = 0, ret_addr = 0, vec_in = 0;
  logic [7:0] sr_in = 0, acc_in = 0;
  logic busy, push_en, pop_en, pc_load, sr_load, acc_load, done;
  logic [7:0] push_byte, sr_out, acc_out;
  logic [15:0] pc_out;
  logic pop_ack = 0;
  logic [7:0] pop_byte = 0;

  int checks = 0, fails = 0;

  logic [7:0] mem [256];
  logic [7:0] sp = 8'hFF;
  logic [7:0] plog [16];
  int pcount = 0, popcount = 0, wait_c = 0, viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pc_in(pc_in), .ret_addr(ret_addr), .vec_in(vec_in), .sr_in(sr_in), .acc_in(acc_in),
    .busy(busy), .push_en(push_en), .push_byte(push_byte), .pop_en(pop_en),
    .pop_ack(pop_ack), .pop_byte(pop_byte), .pc_out(pc_out), .pc_load(pc_load),
    .sr_out(sr_out), .sr_load(sr_load), .acc_out(acc_out), .acc_load(acc_load), .done(done)
  );

  always @(posedge clk) begin
    pop_ack <= 1'b0;
    if (push_en) begin
      mem[sp] <= push_byte;
      sp <= sp - 8'd1;
      plog[pcount % 16] <= push_byte;
      pcount <= pcount + 1;
    end
    if (pop_en && (wait_c != 0 || pop_ack)) viol <= viol + 1;
    if (pop_en && push_en) viol <= viol + 1;
    if (pop_en) wait_c <= 1 + int'($urandom_range(2, 0));
    else if (wait_c > 0) begin
      wait_c <= wait_c - 1;
      if (wait_c == 1) begin
        pop_ack  <= 1'b1;
        pop_byte <= mem[sp + 8'd1];
        sp <= sp + 8'd1;
        popcount <= popcount + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_bytes(input logic [2:0] op);
    return op[2] ? 1 : (op[1] ? 3 : 2);
  endfunction

  function automatic logic [7:0] exp_push(input logic [2:0] op, input int i,
      input logic [15:0] pc, input logic [15:0] ra, input logic [7:0] sr, input logic [7:0] acc);
    case (op)
      3'd0: return i == 0 ? ra[15:8] : ra[7:0];
      3'd2: return i == 0 ? pc[15:8] : (i == 1 ? pc[7:0] : sr);
      3'd4: return acc;
      default: return sr;
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input bit inject);
    int n, c, pbase, obase;
    logic [7:0] t1, t2, t3;
    logic [15:0] vq;
    n = n_bytes(op);
    pbase = pcount;
    obase = popcount;
    t1 = mem[sp + 8'd1]; t2 = mem[sp + 8'd2]; t3 = mem[sp + 8'd3];
    cmd_valid = 1;
    cmd_op = op;
    pc_in = 16'($urandom); ret_addr = 16'($urandom); vec_in = 16'($urandom);
    sr_in = 8'($urandom); acc_in = 8'($urandom);
    vq = vec_in;
    @(negedge clk);
    c = 1;
    cmd_valid = inject;
    cmd_op = 3'($urandom);
    while (!done && c < 60) begin
      @(negedge clk);
      cmd_valid = 0;
      c++;
    end
    chk(done, "R8 done seen", int'(done), 1);
    if (!op[0]) begin
      chk(c == n + 1, "R1/R3/R5 push latency", c, n + 1);
      chk(pcount - pbase == n, "R1/R3/R5 push count", pcount - pbase, n);
      for (int i = 0; i < n; i++) begin
        logic [7:0] e;
        e = exp_push(op, i, pc_in, ret_addr, sr_in, acc_in);
        chk(plog[(pbase + i) % 16] == e, op == 0 ? "R1 call byte" : (op == 2 ? "R3 irq byte" : "R5 push byte"),
            int'(plog[(pbase + i) % 16]), int'(e));
      end
      chk(pc_load == (op == 3'd2) && !sr_load && !acc_load, "R1/R5 load strobes",
          {pc_load, sr_load, acc_load}, {op == 3'd2, 2'b00});
      if (op == 3'd2) chk(pc_out == vq, "R3 vector load", int'(pc_out), int'(vq));
    end else begin
      chk(popcount - obase == n, "R7 pop count", popcount - obase, n);
      case (op)
        3'd1: begin
          chk(pc_load && !sr_load && !acc_load, "R2 strobes", {pc_load, sr_load, acc_load}, 3'b100);
          chk(pc_out == {t2, t1}, "R2 return pc", int'(pc_out), int'({t2, t1}));
        end
        3'd3: begin
          chk(pc_load && sr_load && !acc_load, "R4 strobes", {pc_load, sr_load, acc_load}, 3'b110);
          chk(sr_out == t1, "R4 status", int'(sr_out), int'(t1));
          chk(pc_out == {t3, t2}, "R4 pc", int'(pc_out), int'({t3, t2}));
        end
        3'd5: begin
          chk(acc_load && !sr_load && !pc_load, "R6 acc strobes", {pc_load, sr_load, acc_load}, 3'b001);
          chk(acc_out == t1, "R6 acc value", int'(acc_out), int'(t1));
        end
        default: begin
          chk(sr_load && !acc_load && !pc_load, "R6 sr strobes", {pc_load, sr_load, acc_load}, 3'b010);
          chk(sr_out == t1, "R6 sr value", int'(sr_out), int'(t1));
        end
      endcase
    end
    @(negedge clk);
    chk(!busy && !done, "R8/R9 idle after done", {busy, done}, 0);
    @(negedge clk);
    chk(!busy && pcount - pbase == (op[0] ? 0 : n) && popcount - obase == (op[0] ? n : 0),
        "R9 stray command ignored", pcount - pbase + popcount - obase, n);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom(32'd7) ^ i);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !push_en && !pop_en && !pc_load && !sr_load && !acc_load,
        "R10 reset state", {busy, done, push_en, pop_en, pc_load, sr_load, acc_load}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int op = 0; op < 8; op++) run(3'(op), 1'b0);
    run(3'd2, 1'b1);
    run(3'd3, 1'b1);
    run(3'd0, 1'b1);
    run(3'd1, 1'b1);
    for (int k = 0; k < 400; k++) run(3'($urandom), 1'($urandom));
    chk(viol == 0, "R7 request protocol", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule